// File: doc/BRIEF.md
# Double-Buffered Serial-to-Parallel Register

This block converts a serial bit stream into an eight-bit parallel word through two register stages. A shift stage takes one bit from `ser_in` on every rising edge of the `shift_clk` line. A storage stage copies the whole shift word on a rising edge of the separate `latch_clk` line. The parallel outputs are driven only from the storage stage. They therefore stay steady while the next word is shifted in. The last shift bit appears on `ser_out`, so several blocks can be chained by feeding one block's `ser_out` into the next block's `ser_in`.

All logic runs on the system clock `clk`. The two strobe lines `shift_clk` and `latch_clk` are plain level inputs that are sampled on that clock. Each strobe line has its own edge tracker, a two-state machine. The states are LINE_HIGH, which is also the reset state, and LINE_LOW. The transition FALL goes from LINE_HIGH to LINE_LOW when the line is seen low. The transition RISE goes from LINE_LOW to LINE_HIGH when the line is seen high, and it is the only transition that emits a one-cycle update pulse.

An active-low clear, `clr_n`, empties the shift stage only. An active-low enable, `oe_n`, connects the storage word to `par_q`; when `oe_n` is high, `par_q` is released to high impedance. Bit 0 of `par_q` is output A, nearest the serial input, and bit 7 is output H, the far end of the chain.

Top module: `sipo_dbl_reg`

## Requirements
- R1: While `rst_n` is low, both stages are cleared at each `clk` edge; right after reset, `par_q` reads 8'h00 with `oe_n` low, and `ser_out` reads 0.
- R2: A `clk` edge that sees a `shift_clk` rise (line high now, low at the previous edge) with `clr_n` high shifts the word left: `ser_in` enters bit 0 (A), bit i moves to bit i+1, and `ser_out` equals bit 7 (H). Bits shifted in oldest-first therefore form the word with the oldest bit at bit 7.
- R3: A `shift_clk` line held high for many cycles causes exactly one shift; with no rise, the shift stage holds.
- R4: A `latch_clk` rise copies the shift word into the storage stage; at every other time the storage stage and `par_q` hold, however many shifts take place.
- R5: `clr_n` low at a `clk` edge forces the shift stage to zero, even when a `shift_clk` rise arrives in the same cycle; `ser_out` then reads 0 and the storage stage is unchanged.
- R6: A `latch_clk` rise in the same cycle as `clr_n` low stores the shift word from before the clear.
- R7: When both strobe lines rise in the same cycle, the storage stage receives the shift word from before that shift.
- R8: With `oe_n` high, all bits of `par_q` are high impedance; `oe_n` does not affect `ser_out` or the contents of either stage.
- R9: Falling strobe edges do nothing, and a strobe line that is already high when reset ends is not counted as a rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low system reset |
| ser_in | input | 1 | Serial data bit taken on a shift strobe |
| shift_clk | input | 1 | Shift strobe line; a rising level advances the shift stage |
| latch_clk | input | 1 | Storage strobe line; a rising level copies the shift word |
| clr_n | input | 1 | Active-low clear of the shift stage only |
| oe_n | input | 1 | Active-low enable of the parallel outputs |
| ser_out | output | 1 | Cascade output, last bit of the shift stage |
| par_q | output | 8 | Parallel outputs A (bit 0) to H (bit 7), high impedance when disabled |

## Verification
The storage capture can coincide either with a shift or with a clear, and in both cases it must take the shift word as it was before that cycle's change. The bench provokes both collisions directly: it raises `latch_clk` with `shift_clk`, and it raises `latch_clk` while `clr_n` is low. In each case it reads `par_q` and expects the old word, not the shifted or cleared one. It then latches again to confirm that the shift stage did take the new value. The random phase produces the same coincidences at random, and a bench model judges every cycle; `par_q` is compared against a pattern the bench puts on the shared bus while the outputs are released.

// File: rtl/sipo_pkg.sv
package sipo_pkg;

    // Tracked level of a strobe line
    typedef enum logic {
        LINE_LOW  = 1'b0,
        LINE_HIGH = 1'b1
    } line_state_t;

endpackage

// File: rtl/sipo_edge_fsm.sv
module sipo_edge_fsm
    import sipo_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic rise_pulse
);

    line_state_t state_q;
    line_state_t state_d;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= LINE_HIGH;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state and output
    always_comb begin
        state_d    = state_q;
        rise_pulse = 1'b0;
        unique case (state_q)
            LINE_LOW: begin
                if (line_in) begin
                    state_d    = LINE_HIGH;   // RISE
                    rise_pulse = 1'b1;
                end
            end
            LINE_HIGH: begin
                if (!line_in) begin
                    state_d = LINE_LOW;       // FALL
                end
            end
            default: begin
                state_d = LINE_HIGH;
            end
        endcase
    end

endmodule

// File: rtl/sipo_shift_stage.sv
module sipo_shift_stage #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_n,
    input  logic             advance,
    input  logic             ser_in,
    output logic [WIDTH-1:0] word
);

    for (genvar i = 0; i < WIDTH; i++) begin : g_cell
        logic feed;
        if (i == 0) begin : g_head
            assign feed = ser_in;
        end else begin : g_body
            assign feed = word[i-1];
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                word[i] <= 1'b0;
            end else if (!clr_n) begin
                word[i] <= 1'b0;
            end else if (advance) begin
                word[i] <= feed;
            end
        end
    end

endmodule

// File: rtl/sipo_hold_stage.sv
module sipo_hold_stage #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (load) begin
            q <= d;
        end
    end

endmodule

// File: rtl/sipo_dbl_reg.sv
module sipo_dbl_reg #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ser_in,
    input  logic             shift_clk,
    input  logic             latch_clk,
    input  logic             clr_n,
    input  logic             oe_n,
    output logic             ser_out,
    output logic [WIDTH-1:0] par_q
);

    localparam int MSB = WIDTH - 1;

    logic             shift_pulse;
    logic             latch_pulse;
    logic [WIDTH-1:0] shift_word;
    logic [WIDTH-1:0] hold_word;

    sipo_edge_fsm u_shift_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_in    (shift_clk),
        .rise_pulse (shift_pulse)
    );

    sipo_edge_fsm u_latch_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_in    (latch_clk),
        .rise_pulse (latch_pulse)
    );

    sipo_shift_stage #(.WIDTH(WIDTH)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_n   (clr_n),
        .advance (shift_pulse),
        .ser_in  (ser_in),
        .word    (shift_word)
    );

    sipo_hold_stage #(.WIDTH(WIDTH)) u_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (latch_pulse),
        .d     (shift_word),
        .q     (hold_word)
    );

    assign ser_out = shift_word[MSB];
    assign par_q   = oe_n ? {WIDTH{1'bz}} : hold_word;

endmodule

// File: rtl/sipo_dbl_reg_chk.sv
module sipo_dbl_reg_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ser_in,
    input logic             shift_clk,
    input logic             latch_clk,
    input logic             clr_n,
    input logic [WIDTH-1:0] shift_word,
    input logic [WIDTH-1:0] hold_word
);

    localparam int MSB = WIDTH - 1;

    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (shift_word == '0 && hold_word == '0));

    assert_shift_move_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $rose(shift_clk) && clr_n)
        |=> shift_word == {$past(shift_word[MSB-1:0]), $past(ser_in)});

    assert_shift_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$rose(shift_clk) && clr_n) |=> $stable(shift_word));

    assert_hold_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$rose(latch_clk)) |=> $stable(hold_word));

    assert_clear_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_n |=> shift_word == '0);

    // R6 and R7: capture takes the pre-update shift word
    assert_latch_old_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $rose(latch_clk)) |=> hold_word == $past(shift_word));

endmodule

bind sipo_dbl_reg sipo_dbl_reg_chk #(.WIDTH(WIDTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ser_in     (ser_in),
    .shift_clk  (shift_clk),
    .latch_clk  (latch_clk),
    .clr_n      (clr_n),
    .shift_word (shift_word),
    .hold_word  (hold_word)
);

// File: tb/test_sipo_dbl_reg.sv
`timescale 1ns/1ps
module test_sipo_dbl_reg;

    localparam logic [7:0] BUS_PAT = 8'h66;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ser_in = 1'b0;
    logic       shift_clk = 1'b0;
    logic       latch_clk = 1'b0;
    logic       clr_n = 1'b1;
    logic       oe_n = 1'b0;
    logic       ser_out;
    wire  [7:0] bus;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // bench model
    logic [7:0] m_sh = '0;
    logic [7:0] m_hd = '0;
    logic       m_psc = 1'b1;
    logic       m_plc = 1'b1;

    always #10 clk = ~clk;

    // another driver on the shared bus while the block is released
    assign bus = oe_n ? BUS_PAT : 8'bzzzzzzzz;

    sipo_dbl_reg i_sipo_dbl_reg (
        .clk       (clk),
        .rst_n     (rst_n),
        .ser_in    (ser_in),
        .shift_clk (shift_clk),
        .latch_clk (latch_clk),
        .clr_n     (clr_n),
        .oe_n      (oe_n),
        .ser_out   (ser_out),
        .par_q     (bus)
    );

    task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic model_edge();
        logic sce, lce;
        if (!rst_n) begin
            m_sh = '0; m_hd = '0; m_psc = 1'b1; m_plc = 1'b1;
        end else begin
            sce = shift_clk && !m_psc;
            lce = latch_clk && !m_plc;
            if (lce) m_hd = m_sh;
            if (!clr_n) m_sh = '0;
            else if (sce) m_sh = {m_sh[6:0], ser_in};
            m_psc = shift_clk;
            m_plc = latch_clk;
        end
    endtask

    // one clock: update model at the edge, compare 2 ns later
    task automatic tick(input string tag);
        @(posedge clk);
        model_edge();
        #2;
        check8({tag, " ser_out"}, {7'd0, ser_out}, {7'd0, m_sh[7]});
        check8({tag, " par_q"}, bus, oe_n ? BUS_PAT : m_hd);
    endtask

    task automatic shift_byte(input logic [7:0] v, input string tag);
        for (int i = 7; i >= 0; i--) begin
            ser_in = v[i]; shift_clk = 1'b1; tick(tag);
            shift_clk = 1'b0; tick(tag);
        end
    endtask

    task automatic latch(input string tag);
        latch_clk = 1'b1; tick(tag);
        latch_clk = 1'b0; tick(tag);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) tick("R1");
        rst_n = 1'b1;
        tick("R1");
        check8("R1 reset par_q", bus, 8'h00);
        check8("R1 reset ser_out", {7'd0, ser_out}, 8'h00);

        // R2: ordering, oldest bit lands at H
        shift_byte(8'hA5, "R2");
        latch("R2");
        check8("R2 word", bus, 8'hA5);
        check8("R2 ser_out is H", {7'd0, ser_out}, 8'h01);

        // R3: long high strobe gives one shift
        ser_in = 1'b0; shift_clk = 1'b1; tick("R3");
        ser_in = 1'b1;
        repeat (5) tick("R3");
        shift_clk = 1'b0; tick("R3");
        latch("R3");
        check8("R3 one shift", bus, 8'h4A);

        // R9: falling edge ignored
        ser_in = 1'b1; shift_clk = 1'b1; tick("R9");
        ser_in = 1'b0; shift_clk = 1'b0;
        repeat (3) tick("R9");
        latch("R9");
        check8("R9 fall ignored", bus, 8'h95);

        // R4: shifting leaves outputs alone
        for (int i = 0; i < 3; i++) begin
            ser_in = 1'b1; shift_clk = 1'b1; tick("R4");
            shift_clk = 1'b0; tick("R4");
        end
        check8("R4 outputs steady", bus, 8'h95);

        // R5: clear beats shift, storage kept
        clr_n = 1'b0; shift_clk = 1'b1; ser_in = 1'b1; tick("R5");
        check8("R5 ser_out low", {7'd0, ser_out}, 8'h00);
        check8("R5 storage kept", bus, 8'h95);
        clr_n = 1'b1; shift_clk = 1'b0; tick("R5");
        latch("R5");
        check8("R5 shift zero", bus, 8'h00);

        // R6: clear and capture together
        shift_byte(8'h71, "R6");
        clr_n = 1'b0; latch_clk = 1'b1; tick("R6");
        check8("R6 pre-clear word", bus, 8'h71);
        clr_n = 1'b1; latch_clk = 1'b0; tick("R6");
        latch("R6");
        check8("R6 cleared after", bus, 8'h00);

        // R7: shift and capture together
        shift_byte(8'hE2, "R7");
        ser_in = 1'b1; shift_clk = 1'b1; latch_clk = 1'b1; tick("R7");
        check8("R7 pre-shift word", bus, 8'hE2);
        shift_clk = 1'b0; latch_clk = 1'b0; tick("R7");
        latch("R7");
        check8("R7 shifted after", bus, 8'hC5);

        // R8: release outputs
        oe_n = 1'b1; tick("R8");
        check8("R8 released", bus, BUS_PAT);
        check8("R8 ser_out unaffected", {7'd0, ser_out}, 8'h01);
        ser_in = 1'b0; shift_clk = 1'b1; tick("R8");
        shift_clk = 1'b0; tick("R8");
        oe_n = 1'b0; tick("R8");
        check8("R8 storage kept", bus, 8'hC5);
        latch("R8");
        check8("R8 shift kept", bus, 8'h8A);

        // R9: line high at reset release is no rise
        rst_n = 1'b0; shift_clk = 1'b1; latch_clk = 1'b1; ser_in = 1'b1;
        repeat (2) tick("R9");
        rst_n = 1'b1;
        repeat (3) tick("R9");
        check8("R9 no rise after reset", bus, 8'h00);
        shift_clk = 1'b0; latch_clk = 1'b0; tick("R9");

        // random mix
        void'($urandom(32'h5EED_0595));
        for (int n = 0; n < 3000; n++) begin
            ser_in    = 1'($urandom);
            shift_clk = ($urandom % 3) != 0 ? ~shift_clk : shift_clk;
            latch_clk = ($urandom % 5) == 0 ? ~latch_clk : latch_clk;
            clr_n     = ($urandom % 20) != 0;
            oe_n      = ($urandom % 6) == 0;
            tick("R4");
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule